// File: doc/BRIEF.md
# MFM Address Mark Detector and Field Checker

This block sits behind a data separator that has already locked onto the preamble. It takes one raw MFM cell per enabled clock. It looks for the 16-cell sync word that carries a missing clock, and it uses each hit to set the byte boundary. It accepts a field only after three such words arrive back to back. The byte after the three sync words names the field: an ID field, a normal data field or a deleted data field.

For an ID field the block collects the cylinder, head, record and size bytes. For a data field it collects a payload whose length comes from the size byte of the last good ID field. The block passes every payload byte out with a strobe. It runs a CRC over the whole field, the trailing check bytes included, and reports the result when the last check byte has been decoded. A controller that has to match sectors reads the ID values. It takes the payload bytes as they stream out.

Top module: `mfm_mark_reader`

## Requirements
- R1: After a synchronous reset every output is zero, and the block waits for a sync word.
- R2: A sync word is only the 16-cell pattern 0x4489, shifted in first cell first. A normally encoded 0xA1 (0x44A9) is decoded as a data byte and never starts a field. Each sync word realigns bytes: each following group of 16 cells is one byte, clock cells at odd positions and data cells at even positions, MSB first.
- R3: A field needs three sync words in a row. If a decoded byte arrives after only one or two, the block drops back to searching silently: no field and no mark error.
- R4: The byte after three sync words selects the field. 0xFE gives field_kind 1 (ID). 0xFB gives field_kind 2 (data) with deleted 0. 0xF8 gives field_kind 2 with deleted 1. field_kind, crc_err and deleted describe the last completed field and hold until the next one completes.
- R5: Any other byte in that place pulses mark_err for one cycle and returns the block to searching, with no field_done and no data strobe.
- R6: An ID field is four bytes (C, H, R, N) followed by two CRC bytes, high byte first. id_c, id_h, id_r and id_n change only when an ID field completes with a good CRC.
- R7: The CRC is CCITT CRC-16 (polynomial 0x1021), preset to 0xFFFF. It runs over the three 0xA1 bytes, the mark byte, the contents and both stored CRC bytes. crc_err is 1 when the final value is not zero.
- R8: A data field carries 128 << N payload bytes, where N is id_n of the last good ID field, clamped to MAX_N. The default MAX_N is 2, so the largest payload is 512 bytes. Before any good ID field, N is 0.
- R9: Every content byte of a field, and no CRC byte, is presented once on data_byte with a one-cycle data_stb pulse, in stream order.
- R10: data_stb and field_done rise two clock cycles after the cycle in which the last cell of the byte is accepted, that is, one cycle after the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cell_vld | input | 1 | A cell is present on cell_bit |
| cell_bit | input | 1 | Raw MFM cell value |
| data_stb | output | 1 | One-cycle strobe for data_byte |
| data_byte | output | 8 | Decoded content byte |
| field_done | output | 1 | Pulse when a field's last CRC byte has been checked |
| field_kind | output | 2 | 1 = ID field, 2 = data field, 0 = none yet |
| crc_err | output | 1 | Last field had a non-zero CRC remainder |
| deleted | output | 1 | Last field was deleted data |
| mark_err | output | 1 | Pulse on an unknown mark byte |
| id_c | output | 8 | Cylinder from last good ID field |
| id_h | output | 8 | Head from last good ID field |
| id_r | output | 8 | Record from last good ID field |
| id_n | output | 8 | Size code from last good ID field |

## Verification
The bench feeds one cell per clock. Two register stages lie between the last cell of a byte and the strobes: the cell decoder, then the field sequencer. So data_stb, field_done, mark_err and the field status are due one edge after the edge that accepted that cell. A single negative-edge monitor records each strobe together with a cycle counter. The field checks compare that counter with the cycle the driver logged for the final CRC cell, and they require a distance of exactly one. Content bytes, error pulses and held status are compared only after a trailing gap, so every result due from the field has already landed.

// File: rtl/mfm_pkg.sv
package mfm_pkg;
  typedef enum logic [1:0] {
    FK_NONE = 2'd0,
    FK_ID   = 2'd1,
    FK_DATA = 2'd2
  } field_kind_t;

  localparam logic [15:0] SYNC_WORD = 16'h4489;
  localparam logic [7:0]  SYNC_BYTE = 8'hA1;
  localparam logic [7:0]  MK_ID     = 8'hFE;
  localparam logic [7:0]  MK_DATA   = 8'hFB;
  localparam logic [7:0]  MK_DEL    = 8'hF8;
  localparam logic [15:0] CRC_POLY  = 16'h1021;
  localparam logic [15:0] CRC_PRE   = 16'hFFFF;

  function automatic logic [15:0] crc_step(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] x;
    logic fb;
    x = c;
    for (int i = 7; i >= 0; i--) begin
      fb = x[15] ^ d[i];
      x  = {x[14:0], 1'b0};
      if (fb) x = x ^ CRC_POLY;
    end
    return x;
  endfunction

  localparam logic [15:0] CRC_SEED =
    crc_step(crc_step(crc_step(CRC_PRE, SYNC_BYTE), SYNC_BYTE), SYNC_BYTE);
endpackage

// File: rtl/mfm_sync_detect.sv
module mfm_sync_detect
  import mfm_pkg::*;
#(
  parameter int WORD_CELLS = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cell_vld,
  input  logic       cell_bit,
  output logic       sync_stb,
  output logic       byte_stb,
  output logic [7:0] byte_val
);
  localparam int CW = $clog2(WORD_CELLS);

  logic [WORD_CELLS-1:0] sr;
  logic [WORD_CELLS-1:0] sr_nx;
  logic [CW-1:0]         cnt;
  logic                  locked;
  logic [7:0]            dbits;

  assign sr_nx = {sr[WORD_CELLS-2:0], cell_bit};

  // data cells sit at the even positions of the word
  for (genvar i = 0; i < 8; i++) begin : g_data
    assign dbits[i] = sr_nx[2*i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sr       <= '0;
      cnt      <= '0;
      locked   <= 1'b0;
      sync_stb <= 1'b0;
      byte_stb <= 1'b0;
      byte_val <= '0;
    end else begin
      sync_stb <= 1'b0;
      byte_stb <= 1'b0;
      if (cell_vld) begin
        sr <= sr_nx;
        if (sr_nx == SYNC_WORD) begin
          cnt      <= '0;
          locked   <= 1'b1;
          sync_stb <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
          if (locked && cnt == CW'(WORD_CELLS-1)) begin
            byte_stb <= 1'b1;
            byte_val <= dbits;
          end
        end
      end
    end
  end

  // a byte needs a full word of cells after realignment
  p_no_byte_after_sync_r2: assert property (@(posedge clk) disable iff (rst)
    sync_stb |=> !byte_stb);
  p_byte_spacing_r2: assert property (@(posedge clk) disable iff (rst)
    byte_stb |=> !byte_stb);
endmodule

// File: rtl/mfm_crc16.sv
module mfm_crc16
  import mfm_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        init,
  input  logic        upd,
  input  logic [7:0]  din,
  output logic [15:0] crc_q,
  output logic [15:0] crc_nx
);
  assign crc_nx = crc_step(crc_q, din);

  always_ff @(posedge clk) begin
    if (rst)       crc_q <= CRC_PRE;
    else if (init) crc_q <= CRC_SEED;
    else if (upd)  crc_q <= crc_nx;
  end
endmodule

// File: rtl/mfm_field_ctrl.sv
module mfm_field_ctrl
  import mfm_pkg::*;
#(
  parameter int MAX_N  = 2,
  parameter int ID_LEN = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        sync_stb,
  input  logic        byte_stb,
  input  logic [7:0]  byte_val,
  input  logic [15:0] crc_nx,
  output logic        crc_init,
  output logic        crc_upd,
  output logic        data_stb,
  output logic [7:0]  data_byte,
  output logic        field_done,
  output field_kind_t field_kind,
  output logic        crc_err,
  output logic        deleted,
  output logic        mark_err,
  output logic [7:0]  id_c,
  output logic [7:0]  id_h,
  output logic [7:0]  id_r,
  output logic [7:0]  id_n
);
  localparam int MAX_LEN = (128 << MAX_N) + 2;
  localparam int LEN_W   = $clog2(MAX_LEN + 1);
  localparam int NW      = (MAX_N < 1) ? 1 : $clog2(MAX_N + 1);

  typedef enum logic [1:0] {ST_HUNT, ST_SYNC, ST_MARK, ST_FIELD} st_t;

  st_t            state;
  logic [1:0]     nsync;
  logic           is_id;
  logic           del_pend;
  logic [LEN_W-1:0] fcnt;
  logic [LEN_W-1:0] flen_last;
  logic [NW-1:0]  ncur;
  logic [7:0]     idbuf [ID_LEN];
  logic           crc_ok;
  logic [NW-1:0]  n_clamp;

  assign crc_init = sync_stb && ((state == ST_SYNC && nsync == 2'd2) || state == ST_MARK);
  assign crc_upd  = byte_stb && (state == ST_MARK || state == ST_FIELD);
  assign crc_ok   = (crc_nx == 16'h0000);
  assign n_clamp  = (idbuf[ID_LEN-1] > 8'(MAX_N)) ? NW'(MAX_N) : NW'(idbuf[ID_LEN-1]);

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_HUNT;
      nsync      <= '0;
      is_id      <= 1'b0;
      del_pend   <= 1'b0;
      fcnt       <= '0;
      flen_last  <= '0;
      ncur       <= '0;
      data_stb   <= 1'b0;
      data_byte  <= '0;
      field_done <= 1'b0;
      field_kind <= FK_NONE;
      crc_err    <= 1'b0;
      deleted    <= 1'b0;
      mark_err   <= 1'b0;
      id_c       <= '0;
      id_h       <= '0;
      id_r       <= '0;
      id_n       <= '0;
      for (int i = 0; i < ID_LEN; i++) idbuf[i] <= '0;
    end else begin
      data_stb   <= 1'b0;
      field_done <= 1'b0;
      mark_err   <= 1'b0;
      case (state)
        ST_HUNT: if (sync_stb) begin
          nsync <= 2'd1;
          state <= ST_SYNC;
        end
        ST_SYNC: begin
          if (sync_stb) begin
            if (nsync == 2'd2) state <= ST_MARK;
            else nsync <= nsync + 1'b1;
          end else if (byte_stb) begin
            state <= ST_HUNT;
          end
        end
        ST_MARK: if (byte_stb) begin
          fcnt <= '0;
          case (byte_val)
            MK_ID: begin
              is_id     <= 1'b1;
              del_pend  <= 1'b0;
              flen_last <= LEN_W'(ID_LEN + 1);
              state     <= ST_FIELD;
            end
            MK_DATA, MK_DEL: begin
              is_id     <= 1'b0;
              del_pend  <= (byte_val == MK_DEL);
              flen_last <= LEN_W'((128 << ncur) + 1);
              state     <= ST_FIELD;
            end
            default: begin
              mark_err <= 1'b1;
              state    <= ST_HUNT;
            end
          endcase
        end
        ST_FIELD: begin
          if (sync_stb) begin
            nsync <= 2'd1;
            state <= ST_SYNC;
          end else if (byte_stb) begin
            fcnt <= fcnt + 1'b1;
            if (fcnt < flen_last - LEN_W'(1)) begin
              data_stb  <= 1'b1;
              data_byte <= byte_val;
              if (is_id && fcnt < LEN_W'(ID_LEN)) idbuf[fcnt[1:0]] <= byte_val;
            end
            if (fcnt == flen_last) begin
              field_done <= 1'b1;
              field_kind <= is_id ? FK_ID : FK_DATA;
              crc_err    <= !crc_ok;
              deleted    <= del_pend;
              state      <= ST_HUNT;
              if (is_id && crc_ok) begin
                id_c <= idbuf[0];
                id_h <= idbuf[1];
                id_r <= idbuf[2];
                id_n <= idbuf[3];
                ncur <= n_clamp;
              end
            end
          end
        end
        default: state <= ST_HUNT;
      endcase
    end
  end

  p_id_only_good_r6: assert property (@(posedge clk) disable iff (rst)
    !$stable({id_c, id_h, id_r, id_n}) |-> (field_done && !crc_err && field_kind == FK_ID));
  p_mark_err_alone_r5: assert property (@(posedge clk) disable iff (rst)
    mark_err |-> (!field_done && !data_stb));
  p_done_has_kind_r4: assert property (@(posedge clk) disable iff (rst)
    field_done |-> (field_kind != FK_NONE));
  p_strobe_follows_byte_r10: assert property (@(posedge clk) disable iff (rst)
    data_stb |-> $past(byte_stb));
  p_crc_err_at_done_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(crc_err) |-> field_done);
endmodule

// File: rtl/mfm_mark_reader.sv
module mfm_mark_reader
  import mfm_pkg::*;
#(
  parameter int MAX_N = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cell_vld,
  input  logic       cell_bit,
  output logic       data_stb,
  output logic [7:0] data_byte,
  output logic       field_done,
  output logic [1:0] field_kind,
  output logic       crc_err,
  output logic       deleted,
  output logic       mark_err,
  output logic [7:0] id_c,
  output logic [7:0] id_h,
  output logic [7:0] id_r,
  output logic [7:0] id_n
);
  logic        sync_stb;
  logic        byte_stb;
  logic [7:0]  byte_val;
  logic        crc_init;
  logic        crc_upd;
  logic [15:0] crc_q;
  logic [15:0] crc_nx;
  field_kind_t kind_q;

  mfm_sync_detect #(.WORD_CELLS(16)) u_det (
    .clk(clk), .rst(rst), .cell_vld(cell_vld), .cell_bit(cell_bit),
    .sync_stb(sync_stb), .byte_stb(byte_stb), .byte_val(byte_val)
  );

  mfm_crc16 u_crc (
    .clk(clk), .rst(rst), .init(crc_init), .upd(crc_upd), .din(byte_val),
    .crc_q(crc_q), .crc_nx(crc_nx)
  );

  mfm_field_ctrl #(.MAX_N(MAX_N), .ID_LEN(4)) u_ctrl (
    .clk(clk), .rst(rst), .sync_stb(sync_stb), .byte_stb(byte_stb),
    .byte_val(byte_val), .crc_nx(crc_nx), .crc_init(crc_init), .crc_upd(crc_upd),
    .data_stb(data_stb), .data_byte(data_byte), .field_done(field_done),
    .field_kind(kind_q), .crc_err(crc_err), .deleted(deleted), .mark_err(mark_err),
    .id_c(id_c), .id_h(id_h), .id_r(id_r), .id_n(id_n)
  );

  assign field_kind = kind_q;

  logic unused_crc;
  assign unused_crc = ^crc_q;
endmodule

// File: tb/tb_mfm_mark_reader.sv
module tb_mfm_mark_reader;
  localparam int MAX_N = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cell_vld = 1'b0;
  logic cell_bit = 1'b0;
  logic       data_stb, field_done, crc_err, deleted, mark_err;
  logic [7:0] data_byte, id_c, id_h, id_r, id_n;
  logic [1:0] field_kind;

  mfm_mark_reader #(.MAX_N(MAX_N)) dut (
    .clk(clk), .rst(rst), .cell_vld(cell_vld), .cell_bit(cell_bit),
    .data_stb(data_stb), .data_byte(data_byte), .field_done(field_done),
    .field_kind(field_kind), .crc_err(crc_err), .deleted(deleted),
    .mark_err(mark_err), .id_c(id_c), .id_h(id_h), .id_r(id_r), .id_n(id_n)
  );

  always #4 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int done_cyc = 0;
  int last_cyc = 0;
  int end_cyc = 0;
  int n_done = 0;
  int n_merr = 0;
  logic [7:0] got [$];
  logic [7:0] pay [0:1023];
  logic last_d = 1'b0;
  logic [15:0] crc;
  logic [7:0] exp_c, exp_h, exp_r, exp_n;
  int cur_n = 0;

  always @(negedge clk) begin
    if (data_stb) got.push_back(data_byte);
    if (field_done) begin
      n_done++;
      done_cyc = cyc;
    end
    if (mark_err) n_merr++;
    cyc++;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] crc_b(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] x;
    x = c;
    for (int i = 7; i >= 0; i--) begin
      if (x[15] ^ d[i]) x = {x[14:0], 1'b0} ^ 16'h1021;
      else              x = {x[14:0], 1'b0};
    end
    return x;
  endfunction

  function automatic logic [15:0] enc(input logic [7:0] b, input logic prev);
    logic [15:0] w;
    logic p;
    p = prev;
    for (int i = 7; i >= 0; i--) begin
      w[2*i+1] = ~(p | b[i]);
      w[2*i]   = b[i];
      p        = b[i];
    end
    return w;
  endfunction

  task automatic send_word(input logic [15:0] w);
    for (int i = 15; i >= 0; i--) begin
      @(negedge clk);
      cell_bit = w[i];
      cell_vld = 1'b1;
      @(posedge clk);
      last_cyc = cyc;
    end
  endtask

  task automatic send_byte(input logic [7:0] b);
    send_word(enc(b, last_d));
    last_d = b[0];
  endtask

  task automatic send_sync();
    send_word(16'h4489);
    last_d = 1'b1;
  endtask

  task automatic clear_obs();
    got.delete();
    n_done = 0;
    n_merr = 0;
  endtask

  // preamble, nsync sync words, mark, nbytes from pay, CRC (optionally bad), gap
  task automatic send_field(input logic [7:0] mark, input int nbytes,
                            input bit bad, input int nsync);
    clear_obs();
    for (int i = 0; i < 12; i++) send_byte(8'h00);
    crc = 16'hFFFF;
    for (int i = 0; i < nsync; i++) begin
      send_sync();
      crc = crc_b(crc, 8'hA1);
    end
    crc = crc_b(crc, mark);
    send_byte(mark);
    for (int i = 0; i < nbytes; i++) begin
      crc = crc_b(crc, pay[i]);
      send_byte(pay[i]);
    end
    if (bad) crc = crc ^ 16'h0001;
    send_byte(crc[15:8]);
    send_byte(crc[7:0]);
    end_cyc = last_cyc;
    for (int i = 0; i < 4; i++) send_byte(8'h4E);
  endtask

  task automatic check_payload(input string req, input int nbytes);
    int bad;
    bad = 0;
    chk(got.size() == nbytes, req, "strobed byte count", got.size(), nbytes);
    for (int i = 0; i < nbytes && i < got.size(); i++)
      if (got[i] !== pay[i]) bad++;
    chk(bad == 0, req, "payload mismatches", bad, 0);
  endtask

  task automatic send_id(input logic [7:0] c, input logic [7:0] h,
                         input logic [7:0] r, input logic [7:0] n, input bit bad);
    pay[0] = c; pay[1] = h; pay[2] = r; pay[3] = n;
    send_field(8'hFE, 4, bad, 3);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int len;
    repeat (5) @(posedge clk);
    #1;
    // R1 reset state
    chk({data_stb, field_done, field_kind, crc_err, deleted, mark_err} == 0,
        "R1", "status after reset", {data_stb, field_done, field_kind, crc_err, deleted, mark_err}, 0);
    chk({id_c, id_h, id_r, id_n} == 0, "R1", "id after reset", {id_c, id_h, id_r, id_n}, 0);
    @(negedge clk);
    rst = 1'b0;

    // R4 R6 R8 R9 R10: ID then data, sweep over size codes 0..3
    for (int k = 0; k < 4; k++) begin
      exp_c = 8'(k * 17 + 1); exp_h = 8'(k & 1); exp_r = 8'(k + 1); exp_n = 8'(k);
      send_id(exp_c, exp_h, exp_r, exp_n, 1'b0);
      chk(n_done == 1, "R6", "ID done count", n_done, 1);
      chk(field_kind == 2'd1, "R4", "ID kind", field_kind, 1);
      chk(crc_err == 1'b0, "R7", "ID good crc flag", crc_err, 0);
      chk({id_c, id_h, id_r, id_n} == {exp_c, exp_h, exp_r, exp_n}, "R6", "ID values",
          {id_c, id_h, id_r, id_n}, {exp_c, exp_h, exp_r, exp_n});
      check_payload("R9", 4);
      chk(done_cyc - end_cyc == 1, "R10", "done latency", done_cyc - end_cyc, 1);
      cur_n = (k > MAX_N) ? MAX_N : k;
      len = 128 << cur_n;
      for (int i = 0; i < len; i++) pay[i] = 8'((i * 7 + k * 31) ^ (i >> 3));
      send_field(8'hFB, len, 1'b0, 3);
      chk(n_done == 1, "R8", "data done count", n_done, 1);
      chk(field_kind == 2'd2 && deleted == 1'b0, "R4", "data kind/deleted",
          {field_kind, deleted}, 4);
      chk(crc_err == 1'b0, "R7", "data good crc flag", crc_err, 0);
      check_payload("R8", len);
      chk(done_cyc - end_cyc == 1, "R10", "data done latency", done_cyc - end_cyc, 1);
    end

    // R4 deleted data after an ID with N=0
    send_id(8'h05, 8'h00, 8'h09, 8'h00, 1'b0);
    for (int i = 0; i < 128; i++) pay[i] = 8'(255 - i);
    send_field(8'hF8, 128, 1'b0, 3);
    chk(n_done == 1 && field_kind == 2'd2 && deleted == 1'b1, "R4", "deleted data",
        {n_done[1:0], field_kind, deleted}, 5'b01101);
    check_payload("R9", 128);

    // R7 bad ID CRC: flag set, ID held, length still from N=0
    send_id(8'd99, 8'd1, 8'd2, 8'd1, 1'b1);
    chk(n_done == 1 && crc_err == 1'b1, "R7", "bad ID crc flag", crc_err, 1);
    chk(id_c == 8'h05 && id_n == 8'h00, "R6", "ID held after bad crc", id_c, 5);
    for (int i = 0; i < 128; i++) pay[i] = 8'(i);
    send_field(8'hFB, 128, 1'b1, 3);
    chk(n_done == 1 && crc_err == 1'b1, "R7", "bad data crc flag", crc_err, 1);
    check_payload("R8", 128);

    // R5 unknown mark bytes
    foreach (pay[i]) if (i < 4) pay[i] = 8'h11;
    for (int m = 0; m < 4; m++) begin
      logic [7:0] mk;
      mk = (m == 0) ? 8'hFC : (m == 1) ? 8'hFF : (m == 2) ? 8'h00 : 8'hA1;
      send_field(mk, 4, 1'b0, 3);
      chk(n_merr == 1, "R5", "mark error pulses", n_merr, 1);
      chk(n_done == 0 && got.size() == 0, "R5", "no field on bad mark", n_done, 0);
    end

    // R3 only two sync words
    pay[0] = 8'h01; pay[1] = 8'h02; pay[2] = 8'h03; pay[3] = 8'h00;
    send_field(8'hFE, 4, 1'b0, 2);
    chk(n_done == 0 && n_merr == 0, "R3", "two syncs ignored", n_done + n_merr, 0);
    chk(got.size() == 0, "R3", "no strobes on two syncs", got.size(), 0);

    // R2 normally encoded A1 does not sync
    clear_obs();
    for (int i = 0; i < 12; i++) send_byte(8'h00);
    for (int i = 0; i < 3; i++) send_byte(8'hA1);
    send_byte(8'hFE);
    for (int i = 0; i < 6; i++) send_byte(8'h22);
    for (int i = 0; i < 4; i++) send_byte(8'h4E);
    chk(n_done == 0 && n_merr == 0 && got.size() == 0, "R2", "plain A1 ignored",
        n_done + n_merr + got.size(), 0);
    chk(id_c == 8'h05, "R2", "ID untouched by plain A1", id_c, 5);

    // a good field still follows
    send_id(8'h3C, 8'h01, 8'h07, 8'h02, 1'b0);
    chk(n_done == 1 && id_r == 8'h07 && crc_err == 1'b0, "R2", "resync after noise", id_r, 7);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule